// File: doc/BRIEF.md
# Pseudo-random-addressed RAM delay line

This block delays a stream of 16-bit words by a fixed number of clock-enabled cycles. It does this with synchronous single-port RAM instead of a chain of flip-flops. An 8-bit maximal-length feedback shift register, extended so that it also passes through the all-zero state, steps through all 256 addresses. At each address the stored word is read out and the new input word is written in its place. Because the sequence repeats every 256 steps, each word is read back exactly one period after it was written.

The word is stored in four independent 4-bit slices. Each slice has its own copy of the address generator and its own pipeline register stage for address, write enable and data, so no single counter output drives more than one slice's RAM. Every copy starts from the same seed and advances on the same enable, so all copies stay in lockstep. Each enabled cycle takes one word. When the enable is low, the whole datapath holds, and stalled cycles do not count toward the delay.

A two-state fill controller reports whether the output is meaningful. In state ST_FILL it counts enabled cycles from reset. The transition ST_FILL to ST_RUN is taken on the enabled cycle at which the count reaches 257, which is the 258th enabled cycle. ST_RUN has no exit except reset, which returns the controller to ST_FILL. The valid flag is high exactly in ST_RUN.

Top module: `prand_ram_delay`

## Requirements
- R1: After the N-th enabled clock edge since reset (N counted from 1, N >= 258), dout equals the din word sampled at enabled edge N-257. This is 256 cycles of storage plus one pipeline cycle.
- R2: The address generator visits all 256 addresses, including address zero, once per 256 enabled cycles. As a result, words written over several consecutive periods come back in order, with no aliasing.
- R3: On a clock edge where en is low, dout and dout_vld keep their values, and that edge does not count toward the delay.
- R4: dout_vld is low from reset until the 258th enabled edge and high after that edge. Once high, it stays high until the next reset.
- R5: While rst_n is low, dout is 16'h0000 and dout_vld is 0.
- R6: All four slices use identical addresses in every cycle, so each 4-bit nibble of dout (bits 4k+3..4k) follows the same delay as the whole word.
- R7: A reset applied while the block is running restarts the fill count. dout_vld falls, and the delay is measured again from the first enabled edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable; when high, a word is taken in and the pipeline advances |
| din | input | 16 | Input word |
| dout | output | 16 | Delayed word, registered |
| dout_vld | output | 1 | High when dout holds a word written since reset |

## Verification
Every result is counted in enabled edges, not clock cycles. The word on din at an enabled edge appears on dout just after the 257th enabled edge that follows it. dout_vld rises just after the 258th enabled edge since reset. A disabled edge leaves both outputs unchanged until the next enabled edge. The bench keeps a queue of the words it has presented and a count of enabled edges. It samples the outputs at every falling edge, so it reads the state left by the preceding rising edge, and it indexes the queue by that count. Long runs with the enable held high check the period over several passes. Runs with random stalls and a reset in mid-stream check that stalled edges and earlier data never shift the expected index.

// File: rtl/prand_dly_pkg.sv
package prand_dly_pkg;

    localparam int          DLY_WIDTH  = 16;
    localparam int          DLY_DEPTH  = 256;
    localparam int          DLY_SLICES = 4;
    localparam int          DLY_AW     = $clog2(DLY_DEPTH);
    // feedback taps for x^8 + x^6 + x^5 + x^4 + 1 (bits 7,5,4,3)
    localparam logic [7:0]  DLY_TAPS   = 8'hB8;
    localparam logic [7:0]  DLY_SEED   = 8'h01;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_t;

endpackage

// File: rtl/prand_addr_gen.sv
module prand_addr_gen #(
    parameter int            AW   = 8,
    parameter logic [AW-1:0] TAPS = 8'hB8,
    parameter logic [AW-1:0] SEED = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] q;
    logic          fb;

    // Maximal-length feedback, inverted when the low bits are all zero,
    // so the all-zero state is inserted into the cycle (period 2**AW).
    always_comb begin
        fb = (^(q & TAPS)) ^ (q[AW-2:0] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (en) begin
            q <= {q[AW-2:0], fb};
        end
    end

    assign addr = q;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> addr != $past(addr));

endmodule

// File: rtl/prand_ram.sv
module prand_ram #(
    parameter int DW    = 4,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // storage array: no reset
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // read port: old contents leave in the same cycle they are overwritten
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && we) begin
            rdata <= mem[addr];
        end
    end

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));

endmodule

// File: rtl/prand_slice.sv
module prand_slice #(
    parameter int            SW    = 4,
    parameter int            DEPTH = 256,
    parameter logic [7:0]    TAPS  = 8'hB8,
    parameter logic [7:0]    SEED  = 8'h01,
    localparam int           AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [SW-1:0] din,
    output logic [SW-1:0] dout,
    output logic [AW-1:0] addr_mon
);

    logic [AW-1:0] cur_addr;
    logic [AW-1:0] pipe_addr;
    logic          pipe_we;
    logic [SW-1:0] pipe_data;

    prand_addr_gen #(
        .AW   (AW),
        .TAPS (TAPS[AW-1:0]),
        .SEED (SEED[AW-1:0])
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .addr  (cur_addr)
    );

    // per-slice pipeline stage in front of the RAM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_addr <= '0;
            pipe_we   <= 1'b0;
            pipe_data <= '0;
        end else if (en) begin
            pipe_addr <= cur_addr;
            pipe_we   <= 1'b1;
            pipe_data <= din;
        end
    end

    prand_ram #(
        .DW    (SW),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .we    (pipe_we),
        .addr  (pipe_addr),
        .wdata (pipe_data),
        .rdata (dout)
    );

    assign addr_mon = cur_addr;

    // R1
    pipe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> pipe_addr == $past(cur_addr));

endmodule

// File: rtl/prand_ram_delay.sv
module prand_ram_delay
    import prand_dly_pkg::*;
#(
    parameter int          WIDTH  = DLY_WIDTH,
    parameter int          DEPTH  = DLY_DEPTH,
    parameter int          SLICES = DLY_SLICES,
    parameter logic [7:0]  TAPS   = DLY_TAPS,
    parameter logic [7:0]  SEED   = DLY_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_vld
);

    localparam int AW        = $clog2(DEPTH);
    localparam int SW        = WIDTH / SLICES;
    localparam int FILL_LAST = DEPTH + 1;
    localparam int CW        = $clog2(FILL_LAST + 1);

    logic [AW-1:0] slice_addr [SLICES];

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_slice
            prand_slice #(
                .SW    (SW),
                .DEPTH (DEPTH),
                .TAPS  (TAPS),
                .SEED  (SEED)
            ) u_slice (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (en),
                .din      (din[s*SW +: SW]),
                .dout     (dout[s*SW +: SW]),
                .addr_mon (slice_addr[s])
            );
            if (s > 0) begin : g_lock
                // R6
                addr_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    slice_addr[s] == slice_addr[0]);
            end
        end
    endgenerate

    // fill controller
    fill_state_t    state, state_nx;
    logic [CW-1:0]  fill_cnt, fill_cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state    <= state_nx;
            fill_cnt <= fill_cnt_nx;
        end
    end

    always_comb begin
        state_nx    = state;
        fill_cnt_nx = fill_cnt;
        unique case (state)
            ST_FILL: begin
                if (en) begin
                    if (fill_cnt == CW'(FILL_LAST)) begin
                        state_nx = ST_RUN;
                    end else begin
                        fill_cnt_nx = fill_cnt + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                state_nx = ST_RUN;
            end
        endcase
    end

    always_comb begin
        unique case (state)
            ST_FILL: dout_vld = 1'b0;
            ST_RUN:  dout_vld = 1'b1;
        endcase
    end

    // R4
    vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |=> dout_vld);

    // R4
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_vld) |-> $past(en));

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));

endmodule

// File: tb/prand_ram_delay_bench.sv
module prand_ram_delay_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_vld;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] hist [$];
    int          nen = 0;
    logic [15:0] prev_dout;
    logic        prev_vld;
    logic        last_en = 1'b0;
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    prand_ram_delay u_prand_ram_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge: compare against the model
    task automatic check_outputs(input string req, input bit per_nibble);
        logic        exp_v;
        logic [15:0] exp_d;
        exp_v = (nen >= 258);
        chk("R4", "dout_vld", {15'd0, dout_vld}, {15'd0, exp_v});
        if (!last_en) begin
            chk("R3", "dout held on stall", dout, prev_dout);
            chk("R3", "dout_vld held on stall", {15'd0, dout_vld}, {15'd0, prev_vld});
        end else if (exp_v) begin
            exp_d = hist[nen - 258];
            chk(req, "dout", dout, exp_d);
            if (per_nibble) begin
                for (int k = 0; k < 4; k++) begin
                    // R6: each nibble follows the same delay
                    chk("R6", $sformatf("nibble %0d", k),
                        {12'd0, dout[k*4 +: 4]}, {12'd0, exp_d[k*4 +: 4]});
                end
            end
        end
    endtask

    task automatic step(input bit e, input logic [15:0] d, input string req, input bit per_nibble);
        prev_dout = dout;
        prev_vld  = dout_vld;
        en  = e;
        din = d;
        @(posedge clk);
        if (e) begin
            hist.push_back(d);
            nen++;
        end
        last_en = e;
        @(negedge clk);
        check_outputs(req, per_nibble);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en    = 1'b0;
        repeat (3) @(negedge clk);
        // R5
        chk("R5", "dout in reset", dout, 16'h0000);
        chk("R5", "dout_vld in reset", {15'd0, dout_vld}, 16'h0000);
        hist.delete();
        nen     = 0;
        last_en = 1'b1;
        rst_n   = 1'b1;
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 / R2 / R6: continuous enable, distinct words over several passes
        for (int i = 0; i < 800; i++) begin
            step(1'b1, 16'(i * 16'h0137 + 16'h5A00), (i < 520) ? "R1" : "R2", 1'b1);
        end

        // R3: random stalls
        for (int i = 0; i < 900; i++) begin
            logic [31:0] r;
            r = next_rand();
            step(r[7:6] != 2'b00, r[31:16], "R3", 1'b0);
        end

        // R7: reset in mid-stream, then refill with mostly-enabled traffic
        do_reset();
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = next_rand();
            step(r[5:3] != 3'b000, r[31:16], "R7", 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule